// File: doc/BRIEF.md
# Rate-1/2 Soft-Symbol Depuncturer

This block sits in front of a rate-1/2 Viterbi decoder. A channel stream that was punctured at the transmitter arrives one soft symbol per clock. The block walks a repeating keep/delete pattern for the selected code rate. Wherever the transmitter deleted a bit, it inserts an all-zero soft symbol, which the decoder reads as an erasure. From these it rebuilds the two-symbol columns (first-sent symbol and last-sent symbol) that the decoder consumes.

A column whose two positions were both sent needs two input clocks. The first symbol is held while the block waits for the second. A column with one position sent needs one input clock, and the deleted position is zero-filled. A registered strobe marks each completed pair. The pattern position restarts at column zero after reset and whenever the rate selection changes. The ready output tells the source in which cycles an enabled symbol is taken.

Top module: `depunct_top`

## Requirements
- R1: While reset is high and in the cycle after it, `pair_valid` is low. After reset the pattern restarts at column 0 with no held symbol, and `in_ready` is high whenever reset is low and `rate_sel` equals the rate latched in the previous cycle.
- R2: `pair_out[2*SOFT_W-1:SOFT_W]` carries the first-sent (CA) symbol of a column and `pair_out[SOFT_W-1:0]` carries the last-sent (CB) symbol. When a column sends both, CA is the earlier of its two accepted input symbols.
- R3: Rate codes 0 and 7 select the unpunctured code: every column keeps both positions, so each two accepted symbols form one pair and no zero is inserted.
- R4: Rate codes 1 to 6 select 2/3, 3/4, 4/5, 5/6, 6/7 and 7/8. Each pattern is listed as a string of keep flags per column, from column 0 upward, with CA first and CB second: 2/3 CA 10, CB 11; 3/4 CA 101, CB 110; 4/5 CA 1000, CB 1111; 5/6 CA 10101, CB 11010; 6/7 CA 100101, CB 111010; 7/8 CA 1000101, CB 1111010.
- R5: A deleted position appears in the output pair as an all-zero SOFT_W field.
- R6: `pair_valid` is high for exactly the cycle after the clock edge that accepts the symbol completing a column, and `pair_out` holds that column's pair in that cycle. The column index then advances and wraps to 0 after the pattern's last column.
- R7: A symbol is accepted only in a cycle with `sym_en` and `in_ready` both high. While `sym_en` is low, nothing is latched, the column index and any held CA symbol are kept, and `pair_valid` stays low.
- R8: In a cycle where `rate_sel` differs from the rate in use, `in_ready` is low and the symbol is dropped. At the next edge, the new rate is latched, the column index returns to 0 and any held CA symbol is discarded.
- R9: Reset asserted in the middle of a pattern returns the column index to 0 and discards a held symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sym_in | input | SOFT_W | Received soft symbol, two's complement, 0 = erasure |
| sym_en | input | 1 | Source offers `sym_in` this cycle |
| rate_sel | input | 3 | Code rate select (0/7 unpunctured, 1..6 = 2/3..7/8) |
| in_ready | output | 1 | Block takes an offered symbol this cycle |
| pair_out | output | 2*SOFT_W | Rebuilt pair, CA in upper field, CB in lower field |
| pair_valid | output | 1 | One-cycle strobe for a completed pair |

## Verification
The case of interest is a rate change in the same cycle as an enabled symbol that would complete a column or wrap the pattern. The bench raises `rate_sel` in such cycles while the first half of a two-symbol column is held. It then expects `in_ready` low, no pair in the following cycle, and the next accepted symbols decoded from column 0 of the new pattern without the stale CA symbol. A reset asserted mid-column together with `sym_en` is provoked and judged in the same way.

// File: rtl/depunct_pkg.sv
package depunct_pkg;
  localparam int NUM_RATES  = 8;
  localparam int RATE_W     = 3;
  localparam int MAX_PERIOD = 8;
  localparam int COL_W      = $clog2(MAX_PERIOD);

  typedef struct packed {
    logic [COL_W:0]        period;
    logic [MAX_PERIOD-1:0] keep_a;
    logic [MAX_PERIOD-1:0] keep_b;
  } pattern_t;

  // action taken on an accepted symbol
  typedef enum logic [1:0] {
    ACT_HOLD_A = 2'd0,  // column keeps both: store CA, wait for CB
    ACT_A_ONLY = 2'd1,  // CB deleted: emit {sym, 0}
    ACT_B_ONLY = 2'd2,  // CA deleted: emit {0, sym}
    ACT_JOIN   = 2'd3   // second half of a full column: emit {held, sym}
  } act_t;

  // masks: bit i = column i
  function automatic pattern_t rate_pattern(input int unsigned idx);
    pattern_t p;
    case (idx)
      1: p = '{period: 4'd2, keep_a: 8'b0000_0001, keep_b: 8'b0000_0011};
      2: p = '{period: 4'd3, keep_a: 8'b0000_0101, keep_b: 8'b0000_0011};
      3: p = '{period: 4'd4, keep_a: 8'b0000_0001, keep_b: 8'b0000_1111};
      4: p = '{period: 4'd5, keep_a: 8'b0001_0101, keep_b: 8'b0000_1011};
      5: p = '{period: 4'd6, keep_a: 8'b0010_1001, keep_b: 8'b0001_0111};
      6: p = '{period: 4'd7, keep_a: 8'b0101_0001, keep_b: 8'b0010_1111};
      default: p = '{period: 4'd1, keep_a: 8'b0000_0001, keep_b: 8'b0000_0001};
    endcase
    return p;
  endfunction
endpackage

// File: rtl/depunct_pattern_lut.sv
module depunct_pattern_lut
  import depunct_pkg::*;
(
  input  logic [RATE_W-1:0] rate,
  input  logic [COL_W-1:0]  col,
  output logic              keep_a,
  output logic              keep_b,
  output logic              last_col
);
  logic [NUM_RATES-1:0] ka_vec, kb_vec, last_vec;

  for (genvar r = 0; r < NUM_RATES; r++) begin : g_rate
    localparam pattern_t PAT = rate_pattern(r);
    assign ka_vec[r]   = PAT.keep_a[col];
    assign kb_vec[r]   = PAT.keep_b[col];
    assign last_vec[r] = ({1'b0, col} == PAT.period - 1'b1);
  end

  assign keep_a   = ka_vec[rate];
  assign keep_b   = kb_vec[rate];
  assign last_col = last_vec[rate];
endmodule

// File: rtl/depunct_col_seq.sv
module depunct_col_seq
  import depunct_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             accept,
  input  logic             keep_a,
  input  logic             keep_b,
  input  logic             last_col,
  output logic [COL_W-1:0] col,
  output act_t             act
);
  logic half;   // CA of a full column already held
  logic done;   // this accept completes the column

  always_comb begin
    if (half)                 act = ACT_JOIN;
    else if (keep_a && keep_b) act = ACT_HOLD_A;
    else if (keep_a)          act = ACT_A_ONLY;
    else                      act = ACT_B_ONLY;
  end

  assign done = accept && (act != ACT_HOLD_A);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      col  <= '0;
      half <= 1'b0;
    end else if (accept) begin
      half <= (act == ACT_HOLD_A);
      if (done) col <= last_col ? '0 : col + 1'b1;
    end
  end
endmodule

// File: rtl/depunct_pair_build.sv
module depunct_pair_build
  import depunct_pkg::*;
#(
  parameter int SOFT_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                restart,
  input  logic                accept,
  input  act_t                act,
  input  logic [SOFT_W-1:0]   sym,
  output logic [2*SOFT_W-1:0] pair_out,
  output logic                pair_valid
);
  localparam logic [SOFT_W-1:0] ERASE = '0;
  logic [SOFT_W-1:0] held_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      pair_valid <= 1'b0;
      pair_out   <= '0;
      held_a     <= ERASE;
    end else begin
      pair_valid <= 1'b0;
      if (restart) begin
        held_a <= ERASE;
      end else if (accept) begin
        case (act)
          ACT_HOLD_A: held_a <= sym;
          ACT_A_ONLY: begin pair_out <= {sym, ERASE};    pair_valid <= 1'b1; end
          ACT_B_ONLY: begin pair_out <= {ERASE, sym};    pair_valid <= 1'b1; end
          default:    begin pair_out <= {held_a, sym};   pair_valid <= 1'b1; end
        endcase
      end
    end
  end
endmodule

// File: rtl/depunct_top.sv
module depunct_top
  import depunct_pkg::*;
#(
  parameter int SOFT_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SOFT_W-1:0]   sym_in,
  input  logic                sym_en,
  input  logic [RATE_W-1:0]   rate_sel,
  output logic                in_ready,
  output logic [2*SOFT_W-1:0] pair_out,
  output logic                pair_valid
);
  logic [RATE_W-1:0] rate_q;
  logic              rate_chg, accept;
  logic              keep_a, keep_b, last_col;
  logic [COL_W-1:0]  col;
  act_t              act;

  always_ff @(posedge clk) begin
    if (rst || rate_chg) rate_q <= rate_sel;
  end

  assign rate_chg = (rate_sel != rate_q);
  assign in_ready = !rst && !rate_chg;
  assign accept   = sym_en && in_ready;

  depunct_pattern_lut u_lut (
    .rate(rate_q), .col(col),
    .keep_a(keep_a), .keep_b(keep_b), .last_col(last_col)
  );

  depunct_col_seq u_seq (
    .clk(clk), .rst(rst), .restart(rate_chg), .accept(accept),
    .keep_a(keep_a), .keep_b(keep_b), .last_col(last_col),
    .col(col), .act(act)
  );

  depunct_pair_build #(.SOFT_W(SOFT_W)) u_build (
    .clk(clk), .rst(rst), .restart(rate_chg), .accept(accept),
    .act(act), .sym(sym_in),
    .pair_out(pair_out), .pair_valid(pair_valid)
  );
endmodule

// File: rtl/depunct_checker.sv
module depunct_checker
  import depunct_pkg::*;
#(
  parameter int SOFT_W = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                sym_en,
  input logic [RATE_W-1:0]   rate_sel,
  input logic                in_ready,
  input logic                pair_valid
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !pair_valid); // R1

  AST_NO_TAKE_NO_PAIR: assert property (@(posedge clk) disable iff (rst)
    !(sym_en && in_ready) |=> !pair_valid); // R7

  AST_UNPUNCT_SPACING: assert property (@(posedge clk) disable iff (rst)
    (pair_valid && in_ready && (rate_sel == 3'd0)) |=> !pair_valid); // R3

  AST_READY_STEADY_RATE: assert property (@(posedge clk) disable iff (rst)
    ($stable(rate_sel) && !$past(rst)) |-> in_ready); // R8

  AST_DROP_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    !$stable(rate_sel) |-> !in_ready); // R8
endmodule

bind depunct_top depunct_checker #(.SOFT_W(SOFT_W)) u_chk (
  .clk(clk), .rst(rst), .sym_en(sym_en), .rate_sel(rate_sel),
  .in_ready(in_ready), .pair_valid(pair_valid)
);

// File: tb/tb_depunct_top.sv
`timescale 1ns/1ps
module tb_depunct_top;
  localparam int W = 4;

  logic           clk = 1'b0;
  logic           rst;
  logic [W-1:0]   sym_in;
  logic           sym_en;
  logic [2:0]     rate_sel;
  logic           in_ready;
  logic [2*W-1:0] pair_out;
  logic           pair_valid;

  always #10 clk = ~clk;  // 50 MHz

  depunct_top #(.SOFT_W(W)) dut (
    .clk(clk), .rst(rst), .sym_in(sym_in), .sym_en(sym_en),
    .rate_sel(rate_sel), .in_ready(in_ready),
    .pair_out(pair_out), .pair_valid(pair_valid)
  );

  int checks = 0, fails = 0;
  string req = "R1";

  // model state
  int       m_rate = 0, m_col = 0;
  bit       m_half = 0;
  logic [W-1:0]   m_hold = '0;
  bit       ev = 0;
  logic [2*W-1:0] ep = '0;

  function automatic string pat(input int r, input bit b);
    case (r)
      1: return b ? "11"      : "10";
      2: return b ? "110"     : "101";
      3: return b ? "1111"    : "1000";
      4: return b ? "11010"   : "10101";
      5: return b ? "111010"  : "100101";
      6: return b ? "1111010" : "1000101";
      default: return "1";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit en, input logic [W-1:0] s, input int r, input bit rs);
    bit ka, kb;
    string pa, pb;
    sym_en = en; sym_in = s; rate_sel = r[2:0]; rst = rs;
    #1;
    chk((r != m_rate && !rs) ? "R8" : req, {31'd0, in_ready}, {31'd0, (!rs && r == m_rate)});
    ev = 0;
    if (rs) begin
      m_rate = r; m_col = 0; m_half = 0;
    end else if (r != m_rate) begin
      m_rate = r; m_col = 0; m_half = 0;
    end else if (en) begin
      pa = pat(m_rate, 0); pb = pat(m_rate, 1);
      ka = (pa[m_col] == "1"); kb = (pb[m_col] == "1");
      if (m_half) begin
        ev = 1; ep = {m_hold, s}; m_half = 0;
      end else if (ka && kb) begin
        m_hold = s; m_half = 1;
      end else if (ka) begin
        ev = 1; ep = {s, {W{1'b0}}};
      end else begin
        ev = 1; ep = {{W{1'b0}}, s};
      end
      if (ev) m_col = (m_col + 1 == pa.len()) ? 0 : m_col + 1;
    end
    @(negedge clk);
    chk({req, " valid"}, {31'd0, pair_valid}, {31'd0, ev});
    if (ev) chk({req, " pair"}, {24'd0, pair_out}, {24'd0, ep});
  endtask

  function automatic logic [W-1:0] val(input int k);
    return W'((k % 15) + 1);  // never the erasure code
  endfunction

  initial begin
    #(20 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    sym_en = 0; sym_in = '0; rate_sel = 3'd0; rst = 1;
    @(negedge clk);
    req = "R1";
    step(0, '0, 0, 1);
    step(1, 4'h5, 0, 1);
    step(0, '0, 0, 0);
    chk("R1 ready", {31'd0, in_ready}, 32'd1);

    // R2/R3: unpunctured, CA first in upper field
    req = "R2";
    step(1, 4'h9, 0, 0);
    step(1, 4'h3, 0, 0);
    req = "R3";
    for (int k = 0; k < 20; k++) step(1, val(k), 0, 0);
    step(0, '0, 7, 0);
    for (int k = 0; k < 10; k++) step(1, val(k + 3), 7, 0);

    // R4/R5/R6: every punctured rate, several periods, continuous input
    for (int r = 1; r <= 6; r++) begin
      req = "R4";
      step(0, '0, r, 0);
      for (int k = 0; k < 6 * (r + 2); k++) begin
        req = (k % 3 == 0) ? "R5" : ((k % 3 == 1) ? "R6" : "R4");
        step(1, val(k + r), r, 0);
      end
    end

    // R7: gaps in enable, including inside full columns
    for (int r = 0; r <= 6; r++) begin
      req = "R7";
      step(0, '0, r, 0);
      for (int k = 0; k < 40; k++) step((k % 5) != 3 && (k % 7) != 2, val(k), r, 0);
    end

    // R8: rate change in the cycle that would complete a held column
    req = "R8";
    step(0, '0, 3, 0);
    step(1, 4'h7, 3, 0);      // column 0 of 4/5: holds CA
    step(1, 4'hA, 5, 0);      // change with enable: dropped
    for (int k = 0; k < 14; k++) step(1, val(k), 5, 0);
    step(1, 4'h2, 6, 0);      // change again mid pattern
    for (int k = 0; k < 16; k++) step(1, val(k + 5), 6, 0);

    // R9: reset mid column with enable high
    req = "R9";
    step(1, 4'h4, 6, 0);
    step(1, 4'hC, 6, 1);
    for (int k = 0; k < 16; k++) step(1, val(k + 9), 6, 0);
    step(1, 4'h1, 2, 0);
    step(1, 4'h6, 2, 0);
    step(1, 4'hE, 2, 1);
    for (int k = 0; k < 12; k++) step(1, val(k), 2, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule